// File: doc/BRIEF.md
# Write Data Byte Parity Checker

This block sits on the write-data path of a synchronous SRAM port and checks each write beat. The data word is split into 9-bit lanes. In each lane the low eight bits carry data and the top bit carries parity. On every accepted beat, each enabled lane is checked against the selected parity sense, even or odd. The per-lane mismatches are ORed into a single registered error flag. How long the flag takes to appear depends on the port's access mode. In flow-through mode it arrives one cycle after the beat. In pipelined mode it arrives one cycle later than that, so that it lines up with where read data would appear.

A beat is accepted in any cycle where `wr_valid` is high. The checker never applies back-pressure, so it has no ready signal. The producer may hold `wr_valid` high on every cycle, and each such cycle counts as a separate beat. A second mode serves narrow ports that carry eight bits per byte. In that mode the checker computes each lane's parity bit from its data bits and places it in the outgoing word, and it reports no errors. In check mode the outgoing word is the incoming word, unchanged.

Top module: `wr_parity_chk`

## Requirements
- R1: Lane i occupies `wr_data[9i+8:9i]`, and bit 9i+8 is its parity bit. With `odd_sel`=0, an enabled lane on a valid beat is in error when the XOR of its nine bits is 1.
- R2: With `odd_sel`=1, an enabled lane on a valid beat is in error when the XOR of its nine bits is 0.
- R3: With `pipe_mode`=0, an erroneous beat presented in cycle n raises `par_err` in cycle n+1.
- R4: With `pipe_mode`=1, an erroneous beat presented in cycle n leaves `par_err` low in cycle n+1 and raises it in cycle n+2.
- R5: A lane whose `wr_be` bit is 0 never contributes an error, whatever its contents.
- R6: Two kinds of beat never raise `par_err`: a cycle with `wr_valid` low, and an aborted write, meaning `wr_valid` high with all `wr_be` bits 0.
- R7: `par_err` is high for exactly one cycle per erroneous beat. This holds when several lanes of the same beat are bad. Back-to-back bad beats give back-to-back high cycles.
- R8: With `gen_mode`=1, `par_err` is never raised. In `out_data`, each lane keeps its eight data bits and its parity bit is replaced by the bit that makes the lane meet the selected sense.
- R9: With `gen_mode`=0, `out_data` equals `wr_data`.
- R10: Reset (`rst_n` low, asynchronous) clears `par_err` and its delay stage. An error that was in flight when reset hit is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present this cycle |
| wr_data | input | 9*NUM_BYTES | Write word, one 9-bit lane per byte |
| wr_be | input | NUM_BYTES | Per-lane byte enable, active high |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| pipe_mode | input | 1 | 0 = flow-through latency, 1 = pipelined latency |
| gen_mode | input | 1 | 1 = generate parity instead of checking |
| out_data | output | 9*NUM_BYTES | Write word, with generated parity bits when `gen_mode`=1 |
| par_err | output | 1 | Registered parity error flag |

## Verification
The latency properties assume that `pipe_mode` and `gen_mode` are static configuration. A change is tolerated only where the properties sample the mode on each cycle they span. The stimulus sets the modes only while the bus is idle, and it leaves a drain cycle before changing them. The generated-parity property assumes that `wr_data` and `odd_sel` are driven to known values whenever reset is released. The bench drives every input from time zero.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int LANE_W  = 9;
  localparam int DATA_W  = 8;
  localparam int PAR_BIT = LANE_W - 1;

  function automatic logic data_xor(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/wpc_lane.sv
module wpc_lane
  import wpc_pkg::*;
(
  input  logic [LANE_W-1:0] lane_in,
  input  logic              en,
  input  logic              odd_sel,
  input  logic              gen_mode,
  output logic              mismatch,
  output logic [LANE_W-1:0] lane_out
);
  logic dpar;
  logic gen_bit;

  always_comb begin
    dpar     = data_xor(lane_in[DATA_W-1:0]);
    gen_bit  = dpar ^ odd_sel;
    mismatch = en & ~gen_mode & ((dpar ^ lane_in[PAR_BIT]) != odd_sel);
    lane_out = gen_mode ? {gen_bit, lane_in[DATA_W-1:0]} : lane_in;
  end
endmodule

// File: rtl/wpc_err_delay.sv
module wpc_err_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic pipe_mode,
  output logic err_o
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      stage1_q <= hit;
      err_o    <= pipe_mode ? stage1_q : hit;
    end
  end
endmodule

// File: rtl/wr_parity_chk.sv
module wr_parity_chk
  import wpc_pkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [LANE_W*NUM_BYTES-1:0] wr_data,
  input  logic [NUM_BYTES-1:0]        wr_be,
  input  logic                        odd_sel,
  input  logic                        pipe_mode,
  input  logic                        gen_mode,
  output logic [LANE_W*NUM_BYTES-1:0] out_data,
  output logic                        par_err
);
  logic [NUM_BYTES-1:0] lane_mm;
  logic                 hit_any;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    wpc_lane lane_i (
      .lane_in  (wr_data[g*LANE_W +: LANE_W]),
      .en       (wr_valid & wr_be[g]),
      .odd_sel  (odd_sel),
      .gen_mode (gen_mode),
      .mismatch (lane_mm[g]),
      .lane_out (out_data[g*LANE_W +: LANE_W])
    );
  end

  assign hit_any = |lane_mm;

  wpc_err_delay dly_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit_any),
    .pipe_mode (pipe_mode),
    .err_o     (par_err)
  );
endmodule

// File: rtl/wr_parity_chk_sva.sv
module wr_parity_chk_sva
  import wpc_pkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_valid,
  input logic                        odd_sel,
  input logic                        pipe_mode,
  input logic                        gen_mode,
  input logic                        hit_any,
  input logic [LANE_W*NUM_BYTES-1:0] out_data,
  input logic                        par_err
);
  // R3
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && hit_any) |=> par_err);

  // R4
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && hit_any) ##1 pipe_mode |=> par_err);

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !hit_any) |=> !par_err);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !wr_valid) |=> !par_err);

  // R8
  gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && gen_mode) |=> !par_err);

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_clear_chk: assert (!par_err);
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_gen
    always_comb begin
      if (rst_n && gen_mode) begin
        // R8
        gen_par_ok_chk: assert ((^out_data[g*LANE_W +: LANE_W]) == odd_sel);
      end
    end
  end
endmodule

bind wr_parity_chk wr_parity_chk_sva #(.NUM_BYTES(NUM_BYTES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .odd_sel   (odd_sel),
  .pipe_mode (pipe_mode),
  .gen_mode  (gen_mode),
  .hit_any   (hit_any),
  .out_data  (out_data),
  .par_err   (par_err)
);

// File: tb/wr_parity_chk_tb_top.sv
module wr_parity_chk_tb_top;
  localparam int NB = 2;
  localparam int W  = 9 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic          odd_sel = 1'b0;
  logic          pipe_mode = 1'b0;
  logic          gen_mode = 1'b0;
  logic [W-1:0]  out_data;
  logic          par_err;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  wr_parity_chk #(.NUM_BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_be(wr_be), .odd_sel(odd_sel), .pipe_mode(pipe_mode),
    .gen_mode(gen_mode), .out_data(out_data), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lane with correct (good=1) or wrong parity bit for the sense odd
  function automatic logic [8:0] mk(input logic [7:0] d, input logic good, input logic odd);
    logic p;
    p = (^d) ^ odd;
    if (!good) p = ~p;
    return {p, d};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_valid = 1'b0;
    wr_be    = '0;
    wr_data  = '0;
  endtask

  task automatic beat(input logic [W-1:0] d, input logic [NB-1:0] be);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_be    = be;
    step();
    idle();
  endtask

  task automatic t_reset();
    chk("R10 reset flag", {{(W-1){1'b0}}, par_err}, '0);
    rst_n = 1'b1;
    step();
    chk("R10 after release", {{(W-1){1'b0}}, par_err}, '0);
  endtask

  task automatic t_even();
    odd_sel = 1'b0; pipe_mode = 1'b0;
    beat({mk(8'h3C, 1, 0), mk(8'hA5, 1, 0)}, 2'b11);
    chk("R1 even good", {{(W-1){1'b0}}, par_err}, '0);
    beat({mk(8'h3C, 1, 0), mk(8'h01, 0, 0)}, 2'b11);
    chk("R1 even bad lane0", {{(W-1){1'b0}}, par_err}, 1);
    step();
  endtask

  task automatic t_odd();
    odd_sel = 1'b1; pipe_mode = 1'b0;
    beat({mk(8'h7F, 1, 1), mk(8'h00, 1, 1)}, 2'b11);
    chk("R2 odd good", {{(W-1){1'b0}}, par_err}, '0);
    beat({mk(8'h7F, 0, 1), mk(8'h00, 1, 1)}, 2'b11);
    chk("R2 odd bad lane1", {{(W-1){1'b0}}, par_err}, 1);
    step();
    odd_sel = 1'b0;
  endtask

  task automatic t_flow();
    pipe_mode = 1'b0;
    beat({mk(8'h11, 1, 0), mk(8'h22, 0, 0)}, 2'b11);
    chk("R3 flow n+1", {{(W-1){1'b0}}, par_err}, 1);
    step();
    chk("R7 flow single cycle", {{(W-1){1'b0}}, par_err}, '0);
  endtask

  task automatic t_pipe();
    pipe_mode = 1'b1;
    step();
    beat({mk(8'h11, 1, 0), mk(8'h22, 0, 0)}, 2'b11);
    chk("R4 pipe n+1 low", {{(W-1){1'b0}}, par_err}, '0);
    step();
    chk("R4 pipe n+2 high", {{(W-1){1'b0}}, par_err}, 1);
    step();
    chk("R7 pipe single cycle", {{(W-1){1'b0}}, par_err}, '0);
    step();
    pipe_mode = 1'b0;
    step();
  endtask

  task automatic t_mask();
    beat({mk(8'h5A, 0, 0), mk(8'h5A, 1, 0)}, 2'b01);
    chk("R5 masked lane1", {{(W-1){1'b0}}, par_err}, '0);
    beat({mk(8'h5A, 1, 0), mk(8'h5A, 0, 0)}, 2'b10);
    chk("R5 masked lane0", {{(W-1){1'b0}}, par_err}, '0);
  endtask

  task automatic t_abort();
    wr_valid = 1'b0;
    wr_data  = {mk(8'hF0, 0, 0), mk(8'h0F, 0, 0)};
    wr_be    = 2'b11;
    step();
    chk("R6 invalid beat", {{(W-1){1'b0}}, par_err}, '0);
    beat({mk(8'hF0, 0, 0), mk(8'h0F, 0, 0)}, 2'b00);
    chk("R6 aborted write", {{(W-1){1'b0}}, par_err}, '0);
  endtask

  task automatic t_multi();
    pipe_mode = 1'b0;
    wr_valid = 1'b1; wr_be = 2'b11;
    wr_data = {mk(8'h81, 0, 0), mk(8'h18, 0, 0)};
    step();
    chk("R7 b2b first", {{(W-1){1'b0}}, par_err}, 1);
    wr_data = {mk(8'h81, 1, 0), mk(8'h19, 0, 0)};
    step();
    chk("R7 b2b second", {{(W-1){1'b0}}, par_err}, 1);
    idle();
    step();
    chk("R7 b2b drop", {{(W-1){1'b0}}, par_err}, '0);
  endtask

  task automatic t_gen();
    logic [W-1:0] d;
    gen_mode = 1'b1;
    for (int s = 0; s < 2; s++) begin
      odd_sel = s[0];
      d = {9'h1C3, 9'h0A7};
      wr_valid = 1'b1; wr_be = 2'b11; wr_data = d;
      #1;
      chk("R8 gen word", out_data,
          {mk(d[16:9], 1, s[0]), mk(d[7:0], 1, s[0])});
      step();
      chk("R8 gen no error", {{(W-1){1'b0}}, par_err}, '0);
    end
    idle();
    gen_mode = 1'b0; odd_sel = 1'b0;
    step();
  endtask

  task automatic t_pass();
    wr_data = {9'h155, 9'h0AA};
    #1;
    chk("R9 pass through", out_data, {9'h155, 9'h0AA});
    idle();
  endtask

  task automatic t_reset_mid();
    pipe_mode = 1'b1;
    step();
    beat({mk(8'h01, 0, 0), mk(8'h02, 1, 0)}, 2'b11);
    rst_n = 1'b0;
    #1;
    chk("R10 reset in flight", {{(W-1){1'b0}}, par_err}, '0);
    step();
    rst_n = 1'b1;
    step();
    chk("R10 stage cleared", {{(W-1){1'b0}}, par_err}, '0);
    step();
    chk("R10 stage cleared late", {{(W-1){1'b0}}, par_err}, '0);
    pipe_mode = 1'b0;
  endtask

  initial begin
    #1;
    step();
    t_reset();
    t_even();
    t_odd();
    t_flow();
    t_pipe();
    t_mask();
    t_abort();
    t_multi();
    t_gen();
    t_pass();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule